// File: doc/BRIEF.md
# Dual-Mode LFSR Date-Stamp Generator

This block is a 16-bit linear feedback shift register that serves two purposes. In self-test mode it runs with a maximal-length tap set and walks every nonzero state, so it can act as a pattern source for built-in self-test. In stamp mode a multiplexer puts a deliberately constrained tap word in place of the self-test taps. With this tap word only a small set of final values can be reached, and those values are years spaced far apart.

Reading the stamp takes three steps. Assert the seed-load strobe together with stamp mode. The register then takes a constant seed from a read-only store. Pulse or hold step enable for exactly 50 steps. The register then holds a year coded as four BCD digits, and a one-cycle done flag marks the point where the value is ready. A small change to either the seed or the tap word moves the result to a year far in the past or far in the future, not to a nearby year.

Top module: `datestamp_lfsr`

## Requirements
- R1: After a synchronous active-low reset, `value` is 0x0001 and `done` is 0.
- R2: When `load_seed` is high at a clock edge, `value` becomes the SEED parameter (default 0x2004) and `done` is 0. This holds in either mode and takes priority over `step_en`.
- R3: In stamp mode (`mode_stamp`=1), each edge with `step_en` high shifts `value` one place toward bit 15. The new bit 0 is the XOR of the bits of the old value that are selected by STAMP_TAPS (default 0x05B6).
- R4: With `step_en` and `load_seed` both low, a nonzero `value` does not change.
- R5: `done` is high for exactly one cycle. That cycle is the one after the edge that performs the 50th stamp-mode step since the last load, and `value` then equals the 50-step result.
- R6: Once 50 stamp-mode steps have been taken, further `step_en` in stamp mode leaves `value` unchanged until the next load.
- R7: In self-test mode (`mode_stamp`=0), steps use the taps at bits 15, 13, 12 and 10 (word 0xB400). Starting from the seed, `value` first returns to its start after 65535 steps.
- R8: In self-test mode, a `value` of zero becomes 0x0001 on the next clock edge that does not load.
- R9: A load during a stamp run restarts the step count. `done` then comes 50 steps after the most recent load.
- R10: Steps taken in self-test mode do not count toward the 50 stamp-mode steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_stamp | input | 1 | 1 selects the constrained stamp taps, 0 selects the maximal-length self-test taps |
| load_seed | input | 1 | Loads the stored seed and clears the step count |
| step_en | input | 1 | Advances the register by one step per cycle while high |
| value | output | 16 | Current register contents; after the stamp run, the BCD year |
| done | output | 1 | One-cycle pulse when the 50th stamp-mode step has completed |

## Verification
A straight run of 50 enabled stamp steps is compared at every step against a reference written as a bitwise loop. This separates errors in the tap word from errors in the shift direction. A second run spreads the 50 steps across idle cycles, which shows whether the count tracks real steps or clock cycles. Mixed sequences test the bookkeeping of the step count: a reload partway through a run, and self-test steps placed before stamp steps. A full-period walk in self-test mode confirms the maximal-length taps. A second instance built with a zero seed exercises the lock-up recovery, and also shows that stamp mode leaves zero alone.

// File: rtl/lfsr_stamp_pkg.sv
// Package: shared mode encoding and default constants for the date-stamp LFSR.
// Assumes: users take defaults from here so that top and checker agree.
package lfsr_stamp_pkg;

    typedef enum logic {
        MODE_SELF_TEST = 1'b0,
        MODE_STAMP     = 1'b1
    } lfsr_mode_e;

    localparam int unsigned DEF_WIDTH        = 16;
    localparam logic [15:0] DEF_SEED         = 16'h2004;
    localparam logic [15:0] DEF_STAMP_TAPS   = 16'h05B6;
    localparam logic [15:0] DEF_SELFTST_TAPS = 16'hB400;
    localparam int unsigned DEF_STAMP_STEPS  = 50;

endpackage

// File: rtl/lfsr_tap_select.sv
// Module: picks the active tap word from the operating mode.
// Assumes: mode is stable in the cycle the taps are used; purely combinational.
module lfsr_tap_select
    import lfsr_stamp_pkg::*;
#(
    parameter int unsigned       WIDTH         = DEF_WIDTH,
    parameter logic [WIDTH-1:0]  SELFTST_TAPS  = DEF_SELFTST_TAPS,
    parameter logic [WIDTH-1:0]  STAMP_TAPS    = DEF_STAMP_TAPS
) (
    input  lfsr_mode_e        mode,
    output logic [WIDTH-1:0]  taps
);

    // Mode multiplexer between the maximal-length and constrained tap words.
    always_comb begin
        unique case (mode)
            MODE_STAMP:     taps = STAMP_TAPS;
            default:        taps = SELFTST_TAPS;
        endcase
    end

endmodule

// File: rtl/lfsr_shift_reg.sv
// Module: Fibonacci shift register, shifting toward the MSB, feedback into bit 0.
// Assumes: load beats zero recovery, which beats stepping; reset value is 1.
module lfsr_shift_reg #(
    parameter int unsigned WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WIDTH-1:0]  seed,
    input  logic              advance,
    input  logic [WIDTH-1:0]  taps,
    input  logic              fix_zero,
    output logic [WIDTH-1:0]  q
);

    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] tapped;
    logic             feedback;

    // Per-bit tap gating, one AND per register bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_tap
        assign tapped[i] = q[i] & taps[i];
    end

    // Parity of the tapped bits forms the incoming bit.
    assign feedback = ^tapped;

    // State update: reset, seed load, lock-up escape, or one shift step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= ONE;
        else if (load)
            q <= seed;
        else if (fix_zero && (q == '0))
            q <= ONE;
        else if (advance)
            q <= {q[WIDTH-2:0], feedback};
    end

endmodule

// File: rtl/lfsr_step_tracker.sv
// Module: counts stamp-mode steps since the last load and flags completion.
// Assumes: count_step is only raised for steps the register actually takes.
module lfsr_step_tracker #(
    parameter int unsigned STEPS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic count_step,
    output logic finished,
    output logic done_pulse
);

    localparam int unsigned CNT_W = $clog2(STEPS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS);
    localparam logic [CNT_W-1:0] PENULT = CNT_W'(STEPS - 1);

    logic [CNT_W-1:0] cnt;

    // Saturates at the run length; the register holds once it gets there.
    assign finished = (cnt == LAST);

    // Step counter with a one-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            done_pulse <= 1'b0;
        end else begin
            done_pulse <= 1'b0;
            if (clear) begin
                cnt <= '0;
            end else if (count_step && !finished) begin
                cnt <= cnt + 1'b1;
                if (cnt == PENULT)
                    done_pulse <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/datestamp_lfsr.sv
// Module: dual-mode LFSR; maximal-length self-test patterns or a seeded
// fixed-length run that ends on a BCD year.
// Assumes: mode_stamp is raised together with load_seed for a stamp read.
module datestamp_lfsr
    import lfsr_stamp_pkg::*;
#(
    parameter int unsigned       WIDTH        = DEF_WIDTH,
    parameter logic [WIDTH-1:0]  SEED         = DEF_SEED,
    parameter logic [WIDTH-1:0]  STAMP_TAPS   = DEF_STAMP_TAPS,
    parameter logic [WIDTH-1:0]  SELFTST_TAPS = DEF_SELFTST_TAPS,
    parameter int unsigned       STAMP_STEPS  = DEF_STAMP_STEPS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_stamp,
    input  logic              load_seed,
    input  logic              step_en,
    output logic [WIDTH-1:0]  value,
    output logic              done
);

    lfsr_mode_e       mode;
    logic [WIDTH-1:0] taps;
    logic             stamp_hold;
    logic             advance;

    // Decode the mode pin into the shared enum.
    assign mode = mode_stamp ? MODE_STAMP : MODE_SELF_TEST;

    // Stepping stops in stamp mode once the run length is reached.
    assign advance = step_en && !((mode == MODE_STAMP) && stamp_hold);

    lfsr_tap_select #(
        .WIDTH        (WIDTH),
        .SELFTST_TAPS (SELFTST_TAPS),
        .STAMP_TAPS   (STAMP_TAPS)
    ) tap_sel_i (
        .mode (mode),
        .taps (taps)
    );

    lfsr_shift_reg #(
        .WIDTH (WIDTH)
    ) shreg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_seed),
        .seed     (SEED),
        .advance  (advance),
        .taps     (taps),
        .fix_zero (mode == MODE_SELF_TEST),
        .q        (value)
    );

    lfsr_step_tracker #(
        .STEPS (STAMP_STEPS)
    ) tracker_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (load_seed),
        .count_step (step_en && (mode == MODE_STAMP)),
        .finished   (stamp_hold),
        .done_pulse (done)
    );

endmodule

// File: rtl/datestamp_lfsr_chk.sv
// Module: property checker for datestamp_lfsr, attached by bind.
// Assumes: sees the top's ports plus the tracker's hold flag.
module datestamp_lfsr_chk #(
    parameter int unsigned       WIDTH      = 16,
    parameter logic [WIDTH-1:0]  SEED       = 16'h2004,
    parameter logic [WIDTH-1:0]  STAMP_TAPS = 16'h05B6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_stamp,
    input logic              load_seed,
    input logic              step_en,
    input logic [WIDTH-1:0]  value,
    input logic              done,
    input logic              stamp_hold
);

    a_r2_seed_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        load_seed |=> (value == SEED) && !done);

    a_r3_stamp_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_stamp && step_en && !load_seed && !stamp_hold)
        |=> value == {$past(value[WIDTH-2:0]), ^($past(value) & STAMP_TAPS)});

    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_seed && !step_en && (value != '0)) |=> $stable(value));

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_hold_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_stamp && !load_seed) |=> $stable(value));

    a_r8_zero_escape: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_stamp && !load_seed && (value == '0)) |=> (value == 1));

endmodule

bind datestamp_lfsr datestamp_lfsr_chk #(
    .WIDTH      (WIDTH),
    .SEED       (SEED),
    .STAMP_TAPS (STAMP_TAPS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_stamp (mode_stamp),
    .load_seed  (load_seed),
    .step_en    (step_en),
    .value      (value),
    .done       (done),
    .stamp_hold (stamp_hold)
);

// File: tb/datestamp_lfsr_tb_top.sv
// Directed bench: inputs change on the falling edge, outputs are read one
// falling edge later, after the rising edge that used them.
`timescale 1ns/1ps
module datestamp_lfsr_tb_top;

    localparam logic [15:0] SEED   = 16'h2004;
    localparam logic [15:0] STAMP  = 16'h05B6;
    localparam logic [15:0] SELF   = 16'hB400;
    localparam int          NSTEPS = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_stamp = 1'b0, load_seed = 1'b0, step_en = 1'b0;
    logic        z_mode = 1'b0, z_load = 1'b0, z_step = 1'b0;
    logic [15:0] value, z_value;
    logic        done, z_done;
    int          n_chk = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    datestamp_lfsr dut_i (
        .clk(clk), .rst_n(rst_n), .mode_stamp(mode_stamp), .load_seed(load_seed),
        .step_en(step_en), .value(value), .done(done));

    datestamp_lfsr #(.SEED(16'h0000)) dut_z (
        .clk(clk), .rst_n(rst_n), .mode_stamp(z_mode), .load_seed(z_load),
        .step_en(z_step), .value(z_value), .done(z_done));

    // Reference step written as an explicit bit loop.
    function automatic logic [15:0] ref_step(input logic [15:0] v, input logic [15:0] t);
        logic b = 1'b0;
        for (int k = 0; k < 16; k++)
            if (t[k]) b = b ^ v[k];
        return (v << 1) | {15'd0, b};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input logic m, input logic l, input logic s);
        mode_stamp = m; load_seed = l; step_en = s;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 value", 32'(value), 32'h0001);
        chk("R1 done", 32'(done), 32'h0);
    endtask

    task automatic t_load();
        tick(1, 1, 0);
        chk("R2 seed", 32'(value), 32'(SEED));
        chk("R2 done", 32'(done), 0);
        tick(1, 1, 1);
        chk("R2 load beats step", 32'(value), 32'(SEED));
    endtask

    task automatic t_stamp_run();
        logic [15:0] e = SEED;
        tick(1, 1, 0);
        for (int i = 1; i <= NSTEPS; i++) begin
            e = ref_step(e, STAMP);
            tick(1, 0, 1);
            chk("R3 stamp step", 32'(value), 32'(e));
            chk("R5 done timing", 32'(done), (i == NSTEPS) ? 1 : 0);
        end
        for (int i = 0; i < 3; i++) begin
            tick(1, 0, 1);
            chk("R6 held after run", 32'(value), 32'(e));
            chk("R5 done drops", 32'(done), 0);
        end
    endtask

    task automatic t_gapped();
        logic [15:0] e = SEED;
        int taken = 0;
        tick(1, 1, 0);
        for (int i = 0; taken < NSTEPS; i++) begin
            if (i % 3 == 1) begin
                tick(1, 0, 0);
                chk("R4 idle hold", 32'(value), 32'(e));
                chk("R5 no early done", 32'(done), 0);
            end else begin
                e = ref_step(e, STAMP);
                taken++;
                tick(1, 0, 1);
                chk("R5 gapped done", 32'(done), (taken == NSTEPS) ? 1 : 0);
            end
        end
        chk("R5 gapped value", 32'(value), 32'(e));
    endtask

    task automatic t_reload();
        logic [15:0] e = SEED;
        tick(1, 1, 0);
        for (int i = 0; i < 20; i++) tick(1, 0, 1);
        tick(1, 1, 0);
        for (int i = 1; i <= NSTEPS; i++) begin
            e = ref_step(e, STAMP);
            tick(1, 0, 1);
            if (i == NSTEPS - 1) chk("R9 no done before 50", 32'(done), 0);
        end
        chk("R9 done after reload", 32'(done), 1);
        chk("R9 value after reload", 32'(value), 32'(e));
    endtask

    task automatic t_mixed();
        logic [15:0] e = SEED;
        tick(1, 1, 0);
        for (int i = 0; i < 10; i++) begin
            e = ref_step(e, SELF);
            tick(0, 0, 1);
        end
        chk("R7 self-test steps", 32'(value), 32'(e));
        for (int i = 1; i <= NSTEPS; i++) begin
            e = ref_step(e, STAMP);
            tick(1, 0, 1);
            if (i == NSTEPS - 1) chk("R10 no early done", 32'(done), 0);
        end
        chk("R10 done", 32'(done), 1);
        chk("R10 value", 32'(value), 32'(e));
    endtask

    task automatic t_period();
        int period = 0;
        tick(0, 1, 0);
        for (int i = 1; i <= 70000; i++) begin
            tick(0, 0, 1);
            if (value == SEED) begin
                period = i;
                break;
            end
        end
        chk("R7 period", 32'(period), 32'd65535);
    endtask

    task automatic t_zero();
        z_mode = 1; z_load = 1; z_step = 1;
        @(negedge clk);
        z_load = 0;
        @(negedge clk);
        chk("R8 stamp keeps zero", 32'(z_value), 0);
        z_mode = 0; z_load = 1; z_step = 0;
        @(negedge clk);
        chk("R8 zero loaded", 32'(z_value), 0);
        z_load = 0;
        @(negedge clk);
        chk("R8 zero escape", 32'(z_value), 32'h0001);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load();
        t_stamp_run();
        t_gapped();
        t_reload();
        t_mixed();
        t_period();
        t_zero();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule